// File: doc/BRIEF.md
# Serial EEPROM Page-Erase Command Controller

This block is the slave-side command engine of a small serial EEPROM, restricted to the page-erase path. It oversamples the serial clock, chip select and data-in lines with its own system clock and shifts in data on rising serial-clock edges while chip select is low. It decodes three commands: one that arms the write-enable latch, one that erases a whole page named by a 24-bit address, and one that shifts the status byte out.

An erase is committed only when three conditions hold. Chip select must rise exactly after the 32nd bit of the frame. The write-enable latch must be set. The addressed page must lie outside the region that the two protect bits fence off. A committed erase runs a self-timed cycle that writes FFh into every byte of the page, one byte per clock. The write-in-progress flag is visible in the status byte while that cycle runs. The protect bits come from a configuration input held outside the block. A plain read port on the array lets the surrounding logic see its contents.

Top module: `spi_erase_ctrl`

## Requirements
- R1: After reset the write-enable latch and the busy flag are 0, `so_oe` is 0 and every array byte reads 00h.
- R2: A frame whose opcode is 06h sets the write-enable latch (status bit 1) only when chip select rises after exactly 8 bits. The same opcode followed by more bits, or a frame cut short before 8 bits, leaves the latch unchanged.
- R3: After the opcode 05h has been shifted in, the block drives the status byte {0000, BP1, BP0, latch, busy} MSB first, with BP1:BP0 in bits 3:2. Each bit changes after a falling serial-clock edge and is valid at the next rising edge. The status byte is read this way throughout the bench.
- R4: `so_oe` is 0 whenever no status byte is being shifted out, including after chip select has risen.
- R5: A frame with opcode 42h and a 24-bit address (both MSB first), closed after exactly 32 bits with the latch set and the page unprotected, turns every byte of page address[ADDR_W-1:8] into FFh and leaves all other pages unchanged. Address bits 7:0 and bits at ADDR_W and above play no part.
- R6: An erase frame closed after any bit count other than 32 changes no byte, does not start the busy flag and keeps the latch as it was.
- R7: An erase frame sent while the latch is clear changes no byte and does not start the busy flag.
- R8: The busy flag (status bit 0) goes to 1 when a valid erase is committed and stays at 1 for ERASE_CYC clocks. It then returns to 0, and the latch is cleared at the same point.
- R9: Protect map on the top two address bits: BP=00 protects nothing, 01 protects address[ADDR_W-1:ADDR_W-2]=11, 10 protects address[ADDR_W-1]=1, and 11 protects everything. An erase aimed at a protected page changes no byte, does not start the busy flag and clears the latch.
- R10: While the busy flag is 1, further erase and write-enable frames are ignored. Status reads still work and show the busy flag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in, sampled on rising `sck` |
| bp_cfg | input | 2 | Protect bits BP1:BP0 |
| so_d | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so_d`; 0 means high impedance |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The checks inside the design assume that the serial lines are much slower than `clk`. Each serial-clock level must last several system clocks, and chip select must never change within a few clocks of a serial-clock edge. Only under these conditions do the synchronised copies give one clean edge per transition, and only then is the bit count at chip-select rise well defined. The bench meets this by holding every serial-clock level for six system clocks and by keeping chip select steady for a full half period on both sides of each frame. It also keeps `bp_cfg` stable for the whole of each frame and its erase cycle.

// File: rtl/spi_pe_pkg.sv
package spi_pe_pkg;
   localparam logic [7:0] OP_ARM   = 8'h06;
   localparam logic [7:0] OP_STAT  = 8'h05;
   localparam logic [7:0] OP_ERASE = 8'h42;
   localparam int         CNT_W    = 6;
   localparam int         FRAME_ARM   = 8;
   localparam int         FRAME_ERASE = 32;

   // top two address bits against the protect code
   function automatic logic page_locked(input logic [1:0] bp, input logic [1:0] top2);
      logic r;
      case (bp)
         2'b00:   r = 1'b0;
         2'b01:   r = (top2 == 2'b11);
         2'b10:   r = top2[1];
         default: r = 1'b1;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/spi_pe_sync.sv
module spi_pe_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_pe_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         logic [W-1:0] q;
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= RST_VAL;
               else        q <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= RST_VAL;
               else        q <= g_stage[g-1].q;
            end
         end
      end
   endgenerate

   assign d_out = g_stage[STAGES-1].q;
endmodule

// File: rtl/spi_pe_rx.sv
module spi_pe_rx #(
   parameter int SH_W  = 10,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_s,
   input  logic             sck_s,
   input  logic             si_s,
   output logic             sck_rise,
   output logic             sck_fall,
   output logic             cs_rise,
   output logic [CNT_W-1:0] bit_cnt,
   output logic [SH_W-1:0]  shreg
);
   logic sck_d, cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_n_s;
      end
   end

   assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
   assign sck_fall = ~sck_s & sck_d & ~cs_n_s;
   assign cs_rise  = cs_n_s & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (cs_n_s) begin
         bit_cnt <= '0;
      end else if (sck_rise) begin
         if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
         shreg <= {shreg[SH_W-2:0], si_s};
      end
   end

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt != $past(bit_cnt)) |-> (bit_cnt == '0 || bit_cnt == $past(bit_cnt) + 1'b1));
endmodule

// File: rtl/spi_pe_timer.sv
module spi_pe_timer #(
   parameter int CYC   = 300,
   parameter int OFF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             last,
   output logic             wr_en,
   output logic [OFF_W-1:0] offs
);
   localparam int CW         = $clog2(CYC + 1);
   localparam int PAGE_BYTES = 2 ** OFF_W;

   generate
      if (CYC < PAGE_BYTES) begin : g_bad_cyc
         $error("spi_pe_timer: CYC must cover one write per page byte");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == CW'(CYC - 1)) busy <= 1'b0;
         else                     cnt  <= cnt + 1'b1;
      end
   end

   assign last  = busy && (cnt == CW'(CYC - 1));
   assign wr_en = busy && (cnt < CW'(PAGE_BYTES));
   assign offs  = cnt[OFF_W-1:0];

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !busy);
endmodule

// File: rtl/spi_pe_array.sv
module spi_pe_array #(
   parameter int         ADDR_W = 10,
   parameter int         PAGE_W = 8,
   parameter logic [7:0] FILL   = 8'hFF,
   parameter logic [7:0] INIT   = 8'h00
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     er_we,
   input  logic [ADDR_W-PAGE_W-1:0] er_page,
   input  logic [PAGE_W-1:0]        er_off,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [7:0]               rd_data
);
   localparam int DEPTH = 2 ** ADDR_W;

   logic [7:0]        mem [DEPTH];
   logic [ADDR_W-1:0] wa;

   assign wa = {er_page, er_off};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      end else if (er_we) begin
         mem[wa] <= FILL;
      end
   end

   assign rd_data = mem[rd_addr];

   // R5
   fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      er_we |=> (mem[$past(wa)] == FILL));
endmodule

// File: rtl/spi_erase_ctrl.sv
module spi_erase_ctrl #(
   parameter int ADDR_W      = 10,
   parameter int PAGE_W      = 8,
   parameter int ERASE_CYC   = 300,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   input  logic [1:0]        bp_cfg,
   output logic              so_d,
   output logic              so_oe,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   import spi_pe_pkg::*;

   localparam int PG_IDX_W = ADDR_W - PAGE_W;

   generate
      if (PG_IDX_W < 2) begin : g_bad_pages
         $error("spi_erase_ctrl: array needs at least four pages");
      end
      if (ADDR_W > 24 || ADDR_W < 8) begin : g_bad_addr
         $error("spi_erase_ctrl: ADDR_W must lie in 8..24");
      end
   endgenerate

   logic                cs_n_s, sck_s, si_s;
   logic                sck_rise, sck_fall, cs_rise;
   logic [CNT_W-1:0]    bit_cnt;
   logic [ADDR_W-1:0]   shreg;
   logic [7:0]          op_q;
   logic                wel;
   logic [2:0]          out_idx;
   logic [PG_IDX_W-1:0] page_q;
   logic                t_busy, t_last, t_we;
   logic [PAGE_W-1:0]   t_off;
   logic                cmd_arm, cmd_erase, locked, start, abort_cmd, rd_act;
   logic [7:0]          status;

   spi_pe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({cs_n, sck, si}),
      .d_out ({cs_n_s, sck_s, si_s})
   );

   spi_pe_rx #(.SH_W(ADDR_W), .CNT_W(CNT_W)) rx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_s   (cs_n_s),
      .sck_s    (sck_s),
      .si_s     (si_s),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .cs_rise  (cs_rise),
      .bit_cnt  (bit_cnt),
      .shreg    (shreg)
   );

   // opcode register: loaded on the eighth rising edge of a frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        op_q <= '0;
      else if (sck_rise && bit_cnt == CNT_W'(FRAME_ARM - 1)) op_q <= {shreg[6:0], si_s};
   end

   assign cmd_arm   = cs_rise && (bit_cnt == CNT_W'(FRAME_ARM))   && (op_q == OP_ARM)   && !t_busy;
   assign cmd_erase = cs_rise && (bit_cnt == CNT_W'(FRAME_ERASE)) && (op_q == OP_ERASE) && !t_busy;
   assign locked    = page_locked(bp_cfg, shreg[ADDR_W-1 -: 2]);
   assign start     = cmd_erase && wel && !locked;
   assign abort_cmd = cmd_erase && wel && locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   wel <= 1'b0;
      else if (cmd_arm)             wel <= 1'b1;
      else if (abort_cmd || t_last) wel <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     page_q <= '0;
      else if (start) page_q <= shreg[ADDR_W-1:PAGE_W];
   end

   spi_pe_timer #(.CYC(ERASE_CYC), .OFF_W(PAGE_W)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (t_busy),
      .last  (t_last),
      .wr_en (t_we),
      .offs  (t_off)
   );

   spi_pe_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) array_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .er_we   (t_we),
      .er_page (page_q),
      .er_off  (t_off),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   // status shift-out: bit index follows the falling edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_idx <= '0;
      else if (sck_fall) out_idx <= bit_cnt[2:0];
   end

   assign status = {4'b0000, bp_cfg, wel, t_busy};
   assign rd_act = !cs_n_s && (op_q == OP_STAT) && (bit_cnt >= CNT_W'(FRAME_ARM));
   assign so_oe  = rd_act;
   assign so_d   = rd_act ? status[~out_idx] : 1'b0;

   // R8
   busy_from_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(t_busy) |-> $past(cs_rise));
   // R7
   busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(t_busy) |-> $past(wel));
   // R2
   wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(cs_rise && bit_cnt == CNT_W'(FRAME_ARM)));
   // R10
   busy_keeps_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_busy && $past(t_busy)) |-> $stable(page_q));
endmodule

// File: tb/spi_erase_ctrl_tb_top.sv
module spi_erase_ctrl_tb_top;
   localparam int ADDR_W = 10;
   localparam int PAGE_W = 8;
   localparam int ECYC   = 2000;
   localparam int H      = 6;
   localparam int DEPTH  = 2 ** ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic [1:0]        bp_cfg = 2'b00;
   logic              so_d, so_oe;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [7:0]        rd_data;

   int   total = 0, bad = 0;
   bit   done = 1'b0;
   logic [7:0] exp_mem [DEPTH];

   always #10 clk = ~clk;

   spi_erase_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ERASE_CYC(ECYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .bp_cfg(bp_cfg),
      .so_d(so_d), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // sends pat[39], pat[38], ... for n bits; captures bits 8..15 from SO
   task automatic frame(input logic [39:0] pat, input int n,
                        output logic [7:0] cap, output int oe_hi);
      cap = '0;
      oe_hi = 0;
      cs_n = 1'b0;
      tick(H);
      for (int i = 0; i < n; i++) begin
         si = pat[39-i];
         tick(H);
         if (i >= 8 && i < 16) begin
            cap[15-i] = so_d;
            if (so_oe) oe_hi++;
         end
         sck = 1'b1;
         tick(H);
         sck = 1'b0;
      end
      tick(H);
      cs_n = 1'b1;
      tick(3 * H);
   endtask

   task automatic read_status(output logic [7:0] st, output int oe_hi);
      frame({8'h05, 32'h0}, 16, st, oe_hi);
   endtask

   task automatic arm();
      logic [7:0] c; int o;
      frame({8'h06, 32'h0}, 8, c, o);
   endtask

   task automatic erase(input logic [23:0] a, input int n);
      logic [7:0] c; int o;
      frame({8'h42, a, 8'h00}, n, c, o);
   endtask

   task automatic check_mem(input string req);
      int miss = 0, first = -1;
      logic [7:0] fa = '0, fe = '0;
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = ADDR_W'(a);
         #1;
         if (rd_data !== exp_mem[a]) begin
            miss++;
            if (first < 0) begin first = a; fa = rd_data; fe = exp_mem[a]; end
         end
      end
      check(miss == 0, req, int'(fa), int'(fe));
   endtask

   function automatic logic [23:0] mk_addr(input int pg, input int lo);
      logic [23:0] a;
      a = 24'h5A5A5A;
      a[ADDR_W-1:0] = {PAGE_W'(0) | ADDR_W'(pg << PAGE_W)} | ADDR_W'(lo & 8'hFF);
      return a;
   endfunction

   function automatic bit model_locked(input int bp, input int pg);
      case (bp)
         0: return 1'b0;
         1: return pg == 3;
         2: return pg >= 2;
         default: return 1'b1;
      endcase
   endfunction

   task automatic model_erase(input int pg);
      for (int b = 0; b < 2 ** PAGE_W; b++) exp_mem[(pg << PAGE_W) + b] = 8'hFF;
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] st;
      int oe;
      for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'h00;

      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R1: reset state
      check(so_oe == 1'b0, "R1 so_oe", so_oe, 0);
      check_mem("R1 array");
      read_status(st, oe);
      check(st == 8'h00, "R1 status", st, 8'h00);

      // R3 / R4: status byte with protect bits 10
      bp_cfg = 2'b10;
      read_status(st, oe);
      check(st == 8'h08, "R3 status value", st, 8'h08);
      check(oe == 8, "R3 so_oe during data", oe, 8);
      check(so_oe == 1'b0, "R4 so_oe idle", so_oe, 0);
      bp_cfg = 2'b00;

      // R7: erase with latch clear
      erase(mk_addr(0, 3), 32);
      read_status(st, oe);
      check(st == 8'h00, "R7 no busy", st, 8'h00);
      check_mem("R7 array");

      // R2: bad lengths, then a good arm frame
      frame({8'h06, 32'h0}, 16, st, oe);
      read_status(st, oe);
      check(st == 8'h00, "R2 16-bit arm", st, 8'h00);
      frame({8'h06, 32'h0}, 7, st, oe);
      read_status(st, oe);
      check(st == 8'h00, "R2 7-bit arm", st, 8'h00);
      arm();
      read_status(st, oe);
      check(st == 8'h02, "R2 arm sets latch", st, 8'h02);

      // R6: wrong bit counts
      erase(mk_addr(0, 9), 31);
      read_status(st, oe);
      check(st == 8'h02, "R6 31 bits", st, 8'h02);
      erase(mk_addr(0, 9), 40);
      read_status(st, oe);
      check(st == 8'h02, "R6 40 bits", st, 8'h02);
      check_mem("R6 array");

      // R10: second erase while busy is ignored
      erase(mk_addr(1, 200), 32);
      model_erase(1);
      arm();
      erase(mk_addr(2, 1), 32);
      read_status(st, oe);
      check(st == 8'h03, "R10 busy visible", st, 8'h03);
      tick(ECYC + 50);
      read_status(st, oe);
      check(st == 8'h00, "R10 after erase", st, 8'h00);
      check_mem("R10 array");

      // R5 / R8 / R9: sweep protect codes and pages
      for (int bp = 3; bp >= 0; bp--) begin
         for (int pg = 0; pg < 4; pg++) begin
            bp_cfg = 2'(bp);
            arm();
            erase(mk_addr(pg, pg * 37 + bp), 32);
            read_status(st, oe);
            if (model_locked(bp, pg)) begin
               check(st == 8'(bp << 2), "R9 protected abort", st, bp << 2);
               check_mem("R9 array");
            end else begin
               check(st == 8'((bp << 2) | 3), "R8 busy and latch", st, (bp << 2) | 3);
               tick(ECYC + 50);
               read_status(st, oe);
               check(st == 8'(bp << 2), "R8 done clears", st, bp << 2);
               model_erase(pg);
               check_mem("R5 page erased");
            end
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      done = 1'b1;
      $finish;
   end
endmodule